// File: doc/BRIEF.md
# Management Register Bank for an Emulated 10/100 PHY

This block models the register side of a 10/100 Ethernet PHY as seen through a MAC's management port. It holds sixteen 16-bit registers and sits behind three host-writable management words: an address word that selects a PHY address and a register index, a transmit-data word, and a command word. Writing the command word can start a register write (using the stored transmit data) or a register read. A read places its result in a read-data register. A read also records the current link-down state in a link-fail flag. Only PHY address 1 is served. A read aimed at any other address returns all ones, and a write aimed at any other address is dropped.

A link-state input, passed through a two-stage synchronizer, keeps the link bit of the status register and the link-partner ability register up to date. Writing the control register with its top bit set resets the whole bank to its power-on contents instead of storing the word. The status and both identifier registers cannot be written. Every management strobe completes in the clock in which it is sampled. There is no busy phase and no back-pressure, so the host may issue a strobe on every cycle. Read data is registered and is valid from the cycle after the read strobe.

Top module: `mphy_mgmt_bank`

## Requirements
- R1: After reset the bank reads control (index 0) = 0x1000, status (index 1) = 0x7868, identifiers (indexes 2 and 3) = 0x2000 and 0x5C90, advertisement (index 4) = 0x01E1, and every other index = 0x0000. Both rd_data and link_fail are 0.
- R2: A read command is cmd_we with cmd_wdata bit 1 set. For PHY address 1 it loads the addressed register into rd_data, which is visible on the cycle after the strobe.
- R3: Writes to the status register and to both identifier registers (indexes 1, 2 and 3) leave them unchanged.
- R4: A write to index 0 with bit 15 set does not store the word. Instead it returns every register to its R1 value, with the link terms of R5 applied for the current link state.
- R5: When the synchronized link rises, status bit 2 is set and 0x01E1 is ORed into the partner-ability register (index 5). When it falls, status bit 2 is cleared and index 5 is ANDed with 0x01FF. Both updates land within three clocks of the input change.
- R6: The address word carries the register index in bits 12:8 and the PHY address in bits 4:0. A read to any PHY address other than 1 returns 0xFFFF, and writes to such an address are dropped.
- R7: A txd_we strobe with PHY address 1 writes its data straight into the selected register. A command with cmd_wdata bit 2 set writes the stored transmit data there instead.
- R8: Every read command copies the inverted synchronized link state into link_fail.
- R9: The command word is retained. While its bit 0 (scan) is set, each synchronized link change also updates link_fail. While bit 0 is clear, a link change leaves link_fail alone.
- R10: Register indexes 16 to 31 are not stored. Writes to them change nothing, and reads of them return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Asynchronous link-state input, 1 = link up |
| addr_we | input | 1 | Strobe: load the management address word |
| addr_wdata | input | 16 | Address word (register index 12:8, PHY address 4:0) |
| txd_we | input | 1 | Strobe: load transmit data and write through |
| txd_wdata | input | 16 | Transmit data word |
| cmd_we | input | 1 | Strobe: load command word and act on it |
| cmd_wdata | input | 3 | Command bits: 2 write, 1 read, 0 scan |
| rd_data | output | 16 | Registered result of the last read command |
| link_fail | output | 1 | Link-fail status flag |

## Verification
The in-RTL assertions check on every cycle several fixed behaviours. They confirm that the identifier registers never move, that a dropped write (a write-protected index or an index of 16 or more) leaves the bank untouched, and that a soft reset lands on the control reset value. They also check that a link change reaches the status link bit one cycle later and that foreign-address reads return all ones. On every read they check that link_fail follows the link state. Other behaviours can only be shown by the bench's scenarios. These are the full set of reset values, the OR and mask applied to the partner-ability register across a link up/down sequence, and the difference between the direct write path and the command write path. The scenarios also cover the scan bit's effect on link_fail when no read is issued, and a soft reset taken while the link is up.

// File: rtl/mphy_pkg.sv
package mphy_pkg;
  localparam int DW = 16;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_STAT   = 1;
  localparam int IDX_ID_HI  = 2;
  localparam int IDX_ID_LO  = 3;
  localparam int IDX_ADV    = 4;
  localparam int IDX_PEER   = 5;

  localparam int CTRL_RST_BIT = 15;
  localparam int STAT_LINK_BIT = 2;

  localparam logic [DW-1:0] CTRL_RESET = 16'h1000;
  localparam logic [DW-1:0] STAT_BASE  = 16'h7868;
  localparam logic [DW-1:0] ID_HI_VAL  = 16'h2000;
  localparam logic [DW-1:0] ID_LO_VAL  = 16'h5C90;
  localparam logic [DW-1:0] ABIL_BITS  = 16'h01E1;
  localparam logic [DW-1:0] PEER_KEEP  = 16'h01FF;
  localparam logic [DW-1:0] FOREIGN_RD = 16'hFFFF;

  localparam int CMD_WRITE = 2;
  localparam int CMD_READ  = 1;
  localparam int CMD_SCAN  = 0;

  function automatic logic [DW-1:0] apply_link(input int idx, input logic [DW-1:0] v,
                                               input logic up);
    logic [DW-1:0] r;
    r = v;
    if (idx == IDX_STAT) r[STAT_LINK_BIT] = up;
    else if (idx == IDX_PEER) r = up ? (v | ABIL_BITS) : (v & PEER_KEEP);
    return r;
  endfunction

  function automatic logic [DW-1:0] reset_value(input int idx, input logic up);
    logic [DW-1:0] r;
    case (idx)
      IDX_CTRL:  r = CTRL_RESET;
      IDX_STAT:  r = STAT_BASE;
      IDX_ID_HI: r = ID_HI_VAL;
      IDX_ID_LO: r = ID_LO_VAL;
      IDX_ADV:   r = ABIL_BITS;
      default:   r = '0;
    endcase
    return apply_link(idx, r, up);
  endfunction

  function automatic bit is_protected(input int idx);
    return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
  endfunction
endpackage

// File: rtl/mphy_link_sync.sv
module mphy_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic link_now,
  output logic link_chg
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], link_in};
  end

  assign link_now = chain[STAGES-1];
  assign link_chg = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/mphy_reg_bank.sv
module mphy_reg_bank
  import mphy_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_idx,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          link_chg,
  input  logic                          link_now,
  output logic [REG_COUNT-1:0][DW-1:0]  regs_o
);
  logic soft_rst;
  assign soft_rst = wr_en && (wr_idx == ADDR_W'(IDX_CTRL)) && wr_data[CTRL_RST_BIT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam bit PROT = is_protected(i);
    logic [DW-1:0] q, nx;

    always_comb begin
      nx = q;
      if (link_chg) nx = apply_link(i, nx, link_now);
      if (!PROT && wr_en && (wr_idx == ADDR_W'(i))) nx = wr_data;
      if (soft_rst) nx = reset_value(i, link_now);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= reset_value(i, 1'b0);
      else        q <= nx;
    end

    assign regs_o[i] = q;
  end

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[IDX_ID_HI] == ID_HI_VAL && regs_o[IDX_ID_LO] == ID_LO_VAL); // R3
  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == ADDR_W'(IDX_STAT) && !link_chg |=> $stable(regs_o[IDX_STAT])); // R3
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> regs_o[IDX_CTRL] == CTRL_RESET); // R4
  AST_LINK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |=> regs_o[IDX_STAT][STAT_LINK_BIT] == $past(link_now)); // R5
  AST_HIGH_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) >= REG_COUNT && !link_chg |=> $stable(regs_o)); // R10
endmodule

// File: rtl/mphy_mgmt_port.sv
module mphy_mgmt_port
  import mphy_pkg::*;
#(
  parameter int REG_COUNT  = 16,
  parameter int ADDR_W     = 5,
  parameter int SERVED_PHY = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         addr_we,
  input  logic [DW-1:0]                addr_wdata,
  input  logic                         txd_we,
  input  logic [DW-1:0]                txd_wdata,
  input  logic                         cmd_we,
  input  logic [2:0]                   cmd_wdata,
  input  logic                         link_now,
  input  logic                         link_chg,
  input  logic [REG_COUNT-1:0][DW-1:0] regs_i,
  output logic                         wr_en,
  output logic [ADDR_W-1:0]            wr_idx,
  output logic [DW-1:0]                wr_data,
  output logic [DW-1:0]                rd_data,
  output logic                         link_fail
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic [ADDR_W-1:0] reg_sel_q, phy_sel_q;
  logic [DW-1:0]     txd_q, rd_q;
  logic [2:0]        cmd_q;
  logic              fail_q;
  logic              unused_addr;
  logic              ours, rd_cmd, wr_cmd;
  logic [DW-1:0]     local_rd;

  assign unused_addr = ^{addr_wdata[15:13], addr_wdata[7:5]};
  assign ours   = (phy_sel_q == ADDR_W'(SERVED_PHY));
  assign rd_cmd = cmd_we && cmd_wdata[CMD_READ];
  assign wr_cmd = cmd_we && cmd_wdata[CMD_WRITE];

  assign wr_en   = ours && (txd_we || wr_cmd);
  assign wr_idx  = reg_sel_q;
  assign wr_data = txd_we ? txd_wdata : txd_q;

  always_comb begin
    if (int'(reg_sel_q) < REG_COUNT) local_rd = regs_i[reg_sel_q[IDX_W-1:0]];
    else                             local_rd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_sel_q <= '0;
      phy_sel_q <= '0;
      txd_q     <= '0;
      cmd_q     <= '0;
      rd_q      <= '0;
      fail_q    <= 1'b0;
    end else begin
      if (addr_we) begin
        reg_sel_q <= addr_wdata[8 +: ADDR_W];
        phy_sel_q <= addr_wdata[0 +: ADDR_W];
      end
      if (txd_we) txd_q <= txd_wdata;
      if (cmd_we) cmd_q <= cmd_wdata;
      if (rd_cmd) rd_q <= ours ? local_rd : FOREIGN_RD;
      if (rd_cmd || (cmd_q[CMD_SCAN] && link_chg)) fail_q <= !link_now;
    end
  end

  assign rd_data   = rd_q;
  assign link_fail = fail_q;

  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !ours |=> rd_data == FOREIGN_RD); // R6
  AST_READ_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> link_fail == !$past(link_now)); // R8
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd && !(cmd_q[CMD_SCAN] && link_chg) |=> $stable(link_fail)); // R9
endmodule

// File: rtl/mphy_mgmt_bank.sv
module mphy_mgmt_bank
  import mphy_pkg::*;
#(
  parameter int REG_COUNT   = 16,
  parameter int ADDR_W      = 5,
  parameter int SERVED_PHY  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_up_i,
  input  logic          addr_we,
  input  logic [15:0]   addr_wdata,
  input  logic          txd_we,
  input  logic [15:0]   txd_wdata,
  input  logic          cmd_we,
  input  logic [2:0]    cmd_wdata,
  output logic [15:0]   rd_data,
  output logic          link_fail
);
  logic                         link_now, link_chg, wr_en;
  logic [ADDR_W-1:0]            wr_idx;
  logic [DW-1:0]                wr_data;
  logic [REG_COUNT-1:0][DW-1:0] regs;

  mphy_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .link_in(link_up_i),
    .link_now(link_now), .link_chg(link_chg));

  mphy_reg_bank #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .link_chg(link_chg), .link_now(link_now), .regs_o(regs));

  mphy_mgmt_port #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W), .SERVED_PHY(SERVED_PHY)) u_port (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .txd_we(txd_we), .txd_wdata(txd_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .link_now(link_now), .link_chg(link_chg), .regs_i(regs),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_data(rd_data), .link_fail(link_fail));
endmodule

// File: tb/mphy_mgmt_bank_test.sv
module mphy_mgmt_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up_i = 1'b0;
  logic        addr_we = 1'b0, txd_we = 1'b0, cmd_we = 1'b0;
  logic [15:0] addr_wdata = '0, txd_wdata = '0;
  logic [2:0]  cmd_wdata = '0;
  logic [15:0] rd_data;
  logic        link_fail;
  logic        scan_bit = 1'b0;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        chk_now = 1'b0;

  always #2 clk = ~clk;

  mphy_mgmt_bank uut (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .txd_we(txd_we), .txd_wdata(txd_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .link_fail(link_fail));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read results the cycle after each read strobe
  always @(posedge clk) chk_now <= cmd_we && cmd_wdata[1];
  always @(negedge clk) begin
    if (chk_now) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic set_addr(input int phy, input int rg);
    @(negedge clk);
    addr_we = 1'b1; addr_wdata = 16'((rg << 8) | phy);
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic put_txd(input logic [15:0] v);
    @(negedge clk);
    txd_we = 1'b1; txd_wdata = v;
    @(negedge clk);
    txd_we = 1'b0;
  endtask

  task automatic put_cmd(input logic [2:0] c);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wr_reg(input int phy, input int rg, input logic [15:0] v);
    set_addr(phy, rg);
    put_txd(v);
  endtask

  task automatic rd_reg(input int phy, input int rg, input logic [15:0] exp, input string tag);
    set_addr(phy, rg);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    put_cmd({2'b01, scan_bit});
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    check("R1 rd_data after reset", rd_data, 16'h0);
    check("R1 link_fail after reset", {15'h0, link_fail}, 16'h0);
    rd_reg(1, 0, 16'h1000, "R1 control");
    rd_reg(1, 1, 16'h7868, "R1 status");
    rd_reg(1, 2, 16'h2000, "R1 id hi");
    rd_reg(1, 3, 16'h5C90, "R1 id lo");
    rd_reg(1, 4, 16'h01E1, "R1 advert");
    rd_reg(1, 5, 16'h0000, "R1 peer");
    rd_reg(1, 7, 16'h0000, "R1 other");
    check("R8 link_fail after read, link down", {15'h0, link_fail}, 16'h1);

    wr_reg(1, 4, 16'hABCD);
    rd_reg(1, 4, 16'hABCD, "R7 direct write idx4");
    wr_reg(1, 9, 16'h1234);
    rd_reg(1, 9, 16'h1234, "R2 store idx9");

    wr_reg(0, 10, 16'h5555);
    rd_reg(1, 10, 16'h0000, "R6 write to phy0 dropped");
    rd_reg(2, 2, 16'hFFFF, "R6 foreign phy2 read");
    rd_reg(0, 4, 16'hFFFF, "R6 foreign phy0 read");
    set_addr(1, 10);
    put_cmd(3'b100);
    rd_reg(1, 10, 16'h5555, "R7 command write of stored data");

    wr_reg(1, 1, 16'hFFFF);
    wr_reg(1, 2, 16'h0000);
    wr_reg(1, 3, 16'h1111);
    rd_reg(1, 1, 16'h7868, "R3 status protected");
    rd_reg(1, 2, 16'h2000, "R3 id hi protected");
    rd_reg(1, 3, 16'h5C90, "R3 id lo protected");

    wr_reg(1, 20, 16'hBEEF);
    wr_reg(1, 17, 16'hBEEF);
    rd_reg(1, 20, 16'h0000, "R10 high index reads zero");
    rd_reg(1, 4, 16'hABCD, "R10 idx4 untouched by idx20");
    rd_reg(1, 1, 16'h7868, "R10 idx1 untouched by idx17");

    wr_reg(1, 5, 16'h0002);
    link_up_i = 1'b1;
    wait_cyc(5);
    check("R9 no scan: link_fail unchanged on link up", {15'h0, link_fail}, 16'h1);
    rd_reg(1, 5, 16'h01E3, "R5 peer ORed on link up");
    rd_reg(1, 1, 16'h786C, "R5 status link bit set");
    check("R8 link_fail after read, link up", {15'h0, link_fail}, 16'h0);
    wr_reg(1, 5, 16'hF000);
    link_up_i = 1'b0;
    wait_cyc(5);
    rd_reg(1, 5, 16'h0000, "R5 peer masked on link down");
    rd_reg(1, 1, 16'h7868, "R5 status link bit clear");
    check("R8 link_fail after read, link down again", {15'h0, link_fail}, 16'h1);

    scan_bit = 1'b1;
    put_cmd(3'b001);
    link_up_i = 1'b1;
    wait_cyc(5);
    check("R9 scan: link_fail clears on link up", {15'h0, link_fail}, 16'h0);
    link_up_i = 1'b0;
    wait_cyc(5);
    check("R9 scan: link_fail sets on link down", {15'h0, link_fail}, 16'h1);
    link_up_i = 1'b1;
    wait_cyc(5);
    check("R9 scan: link_fail clears again", {15'h0, link_fail}, 16'h0);

    wr_reg(1, 0, 16'h0100);
    rd_reg(1, 0, 16'h0100, "R2 control stores plain word");
    wr_reg(1, 4, 16'h1111);
    wr_reg(1, 0, 16'h8000);
    rd_reg(1, 0, 16'h1000, "R4 soft reset control");
    rd_reg(1, 4, 16'h01E1, "R4 soft reset advert");
    rd_reg(1, 1, 16'h786C, "R4 soft reset status with link up");
    rd_reg(1, 5, 16'h01E1, "R4 soft reset peer with link up");
    rd_reg(1, 9, 16'h0000, "R4 soft reset clears idx9");

    wait_cyc(2);
    check("scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule